// File: doc/BRIEF.md
# Gate-Controlled Reversible Update ALU

This block is a purely combinational model of a reversible arithmetic-logic network. It operates on two N-bit operands. Operand A always leaves unchanged. The result is written back onto the B lines. A single ancilla line enters and leaves with the same value. Five control lines also pass straight through. Each one enables one group of gates inside a single ripple network: a forward carry ripple followed by a backward uncompute-and-sum ripple.

Nothing selects among results after the fact. Each operation comes from switching gate groups on or off. Subtraction is formed by complementing B before the adder and complementing the result after it. The negative A−B is formed by complementing B and raising the carry-in. Exclusive-or keeps the per-bit pair gates and suppresses the carry-into-sum gates.

Every control setting yields a bijection on the data lines. A parameter selects the mirrored variant, which applies the same gates in reverse order. That variant undoes the forward network, so a caller can uncompute a result.

Top module: `rev_alu`

## Requirements
- R1: Control word `ctl_i` is {negate-B, carry-in enable, pair-XOR enable, carry-into-sum enable, negate-result} from bit 4 down to bit 0. With 5'b00110 and ancilla 0, `r_o` = (B + A) mod 2^N.
- R2: With 5'b10111 and ancilla 0, `r_o` = (B − A) mod 2^N.
- R3: With 5'b11110 and ancilla 0, `r_o` = (A − B) mod 2^N.
- R4: With 5'b00100, `r_o` = B XOR A, whatever the ancilla value.
- R5: With 5'b00000, `r_o` = B.
- R6: The other settings follow from the gate groups. With ancilla 0: 5'b01110 gives B+A+1, 5'b11111 gives B−A−1, 5'b10110 gives A−B−1, 5'b00101 gives NOT(B XOR A) and 5'b00001 gives NOT B, all mod 2^N. In general the B lines are complemented when bit 4 is set. When bits 2 and 1 are both set, the adder adds A plus a carry. When only bit 2 is set, the block XORs A. Finally the result is complemented when bit 0 is set.
- R7: For every setting, `ctl_o` equals `ctl_i` and `a_o` equals `a_i`.
- R8: For every setting, `anc_o` equals `anc_i`. The carry into bit 0 is `anc_i` XOR carry-in enable, so an ancilla of 1 with ADD gives B+A+1.
- R9: For each fixed A, ancilla and control setting, the map from B to `r_o` is a permutation of all 2^N values. This includes settings with carry-into-sum enabled and pair-XOR disabled.
- R10: The variant with INVERT=1 is fed the forward outputs. It returns the original A, B and ancilla for all 32 settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_i | input | 5 | Gate-group enables, bit 4 negate-B down to bit 0 negate-result |
| a_i | input | N | Operand A (preserved) |
| b_i | input | N | Operand B (overwritten by the result) |
| anc_i | input | 1 | Ancilla / carry line, normally 0 |
| ctl_o | output | 5 | Control lines passed through |
| a_o | output | N | Operand A passed through |
| r_o | output | N | Result on the B lines |
| anc_o | output | 1 | Ancilla returned |

## Verification
The in-RTL arithmetic assertions apply only when the ancilla is 0, because the named operations are defined for a clear ancilla. The pass-through assertions hold for any input. The assertions also assume that every input is a known value that is held steady while the network settles, since the block has no clock. The stimulus sets each input vector at a clock edge and keeps it for a full period. It sweeps the ancilla through both values, so both the gated and the ungated regions are reached.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;

    typedef enum logic [1:0] {
        G_CX    = 2'd0,
        G_CCX   = 2'd1,
        G_CSWAP = 2'd2
    } gate_kind_e;

    typedef struct packed {
        gate_kind_e  kind;
        logic [15:0] c0;
        logic [15:0] c1;
        logic [15:0] t0;
        logic [15:0] t1;
    } gate_t;

    // line positions of the control and ancilla wires
    localparam int LN_NEGB = 0;
    localparam int LN_CIN  = 1;
    localparam int LN_AXB  = 2;
    localparam int LN_CSUM = 3;
    localparam int LN_NEGR = 4;
    localparam int LN_ANC  = 5;
    localparam int LN_DATA = 6;

    // named control words, bit 4 = negate-B ... bit 0 = negate-result
    localparam logic [4:0] OP_ADD = 5'b00110;
    localparam logic [4:0] OP_SUB = 5'b10111;
    localparam logic [4:0] OP_NEG = 5'b11110;
    localparam logic [4:0] OP_XOR = 5'b00100;
    localparam logic [4:0] OP_NOP = 5'b00000;

    function automatic int ln_a(input int i);
        return LN_DATA + 2 * i;
    endfunction

    function automatic int ln_b(input int i);
        return LN_DATA + 2 * i + 1;
    endfunction

    // carry line feeding bit i: the ancilla for bit 0, else A line below
    function automatic int ln_c(input int i);
        return (i == 0) ? LN_ANC : ln_a(i - 1);
    endfunction

    function automatic gate_t mk(input gate_kind_e k, input int c0, input int c1,
                                 input int t0, input int t1);
        gate_t g;
        g.kind = k;
        g.c0   = 16'(c0);
        g.c1   = 16'(c1);
        g.t0   = 16'(t0);
        g.t1   = 16'(t1);
        return g;
    endfunction

    // k-th gate of the forward network for an n-bit datapath (6n gates)
    function automatic gate_t gate_at(input int k, input int n);
        int j;
        int i;
        if (k < n) begin
            return mk(G_CX, LN_NEGB, 0, ln_b(k), 0);
        end else if (k == n) begin
            return mk(G_CX, LN_CIN, 0, LN_ANC, 0);
        end else if (k < 3 * n - 1) begin
            j = k - (n + 1);
            i = j / 2;
            if (j % 2 == 0) return mk(G_CCX, LN_AXB, ln_a(i), ln_b(i), 0);
            return mk(G_CSWAP, ln_b(i), 0, ln_a(i), ln_c(i));
        end else if (k == 3 * n - 1) begin
            return mk(G_CCX, LN_AXB, ln_a(n - 1), ln_b(n - 1), 0);
        end else if (k == 3 * n) begin
            return mk(G_CCX, LN_CSUM, ln_c(n - 1), ln_b(n - 1), 0);
        end else if (k < 5 * n - 1) begin
            j = k - (3 * n + 1);
            i = n - 2 - j / 2;
            if (j % 2 == 0) return mk(G_CSWAP, ln_b(i), 0, ln_a(i), ln_c(i));
            return mk(G_CCX, LN_CSUM, ln_c(i), ln_b(i), 0);
        end else if (k == 5 * n - 1) begin
            return mk(G_CX, LN_CIN, 0, LN_ANC, 0);
        end
        return mk(G_CX, LN_NEGR, 0, ln_b(k - 5 * n), 0);
    endfunction

endpackage

// File: rtl/rev_gate_cell.sv
module rev_gate_cell
    import rev_alu_pkg::*;
#(
    parameter int    L    = 14,
    parameter gate_t GATE = '0
) (
    input  logic [L-1:0] in_l,
    output logic [L-1:0] out_l
);
    localparam int C0 = int'(GATE.c0);
    localparam int C1 = int'(GATE.c1);
    localparam int T0 = int'(GATE.t0);
    localparam int T1 = int'(GATE.t1);

    always_comb begin
        out_l = in_l;
        unique case (GATE.kind)
            G_CX:  out_l[T0] = in_l[T0] ^ in_l[C0];
            G_CCX: out_l[T0] = in_l[T0] ^ (in_l[C0] & in_l[C1]);
            G_CSWAP: begin
                if (in_l[C0]) begin
                    out_l[T0] = in_l[T1];
                    out_l[T1] = in_l[T0];
                end
            end
            default: out_l = in_l;
        endcase
    end

    // R9
    always_comb begin
        if (GATE.kind == G_CSWAP) begin
            swap_weight_chk: assert ($countones(out_l) == $countones(in_l))
                else $error("controlled swap changed line weight");
        end
    end
endmodule

// File: rtl/rev_network.sv
module rev_network
    import rev_alu_pkg::*;
#(
    parameter int N      = 16,
    parameter bit INVERT = 1'b0
) (
    input  logic [2*N+5:0] in_l,
    output logic [2*N+5:0] out_l
);
    localparam int L = 2 * N + 6;
    localparam int G = 6 * N;

    logic [L-1:0] stage [G+1];

    assign stage[0] = in_l;

    for (genvar k = 0; k < G; k++) begin : g_gate
        localparam int IDX = INVERT ? (G - 1 - k) : k;
        rev_gate_cell #(
            .L    (L),
            .GATE (gate_at(IDX, N))
        ) u_cell (
            .in_l  (stage[k]),
            .out_l (stage[k+1])
        );
    end

    assign out_l = stage[G];
endmodule

// File: rtl/rev_alu.sv
module rev_alu
    import rev_alu_pkg::*;
#(
    parameter int N      = 16,
    parameter bit INVERT = 1'b0
) (
    input  logic [4:0]   ctl_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         anc_i,
    output logic [4:0]   ctl_o,
    output logic [N-1:0] a_o,
    output logic [N-1:0] r_o,
    output logic         anc_o
);
    localparam int L = 2 * N + 6;

    logic [L-1:0] lines_in;
    logic [L-1:0] lines_out;

    assign lines_in[LN_NEGB] = ctl_i[4];
    assign lines_in[LN_CIN]  = ctl_i[3];
    assign lines_in[LN_AXB]  = ctl_i[2];
    assign lines_in[LN_CSUM] = ctl_i[1];
    assign lines_in[LN_NEGR] = ctl_i[0];
    assign lines_in[LN_ANC]  = anc_i;

    assign ctl_o = {lines_out[LN_NEGB], lines_out[LN_CIN], lines_out[LN_AXB],
                    lines_out[LN_CSUM], lines_out[LN_NEGR]};
    assign anc_o = lines_out[LN_ANC];

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign lines_in[LN_DATA + 2*i]     = a_i[i];
        assign lines_in[LN_DATA + 2*i + 1] = b_i[i];
        assign a_o[i] = lines_out[LN_DATA + 2*i];
        assign r_o[i] = lines_out[LN_DATA + 2*i + 1];
    end

    rev_network #(
        .N      (N),
        .INVERT (INVERT)
    ) u_net (
        .in_l  (lines_in),
        .out_l (lines_out)
    );

    always_comb begin
        // R7
        ctl_pass_chk: assert (ctl_o == ctl_i) else $error("controls altered");
        // R7
        a_pass_chk: assert (a_o == a_i) else $error("operand A altered");
        // R8
        anc_pass_chk: assert (anc_o == anc_i) else $error("ancilla not restored");
    end

    if (!INVERT) begin : g_fwd_chk
        always_comb begin
            if (!anc_i) begin
                // R1
                add_sum_chk: assert (ctl_i != OP_ADD || r_o == N'(b_i + a_i))
                    else $error("ADD result wrong");
                // R2
                sub_diff_chk: assert (ctl_i != OP_SUB || r_o == N'(b_i - a_i))
                    else $error("SUB result wrong");
                // R3
                neg_diff_chk: assert (ctl_i != OP_NEG || r_o == N'(a_i - b_i))
                    else $error("NEG result wrong");
            end
            // R4
            xor_mix_chk: assert (ctl_i != OP_XOR || r_o == (b_i ^ a_i))
                else $error("XOR result wrong");
            // R5
            nop_hold_chk: assert (ctl_i != OP_NOP || r_o == b_i)
                else $error("NOP changed B");
        end
    end
endmodule

// File: tb/rev_alu_tb.sv
module rev_alu_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0]   ctl;
    logic [N-1:0] a, b;
    logic         anc;
    logic [4:0]   ctl_f, ctl_r;
    logic [N-1:0] a_f, r_f, a_r, b_r;
    logic         anc_f, anc_r;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    rev_alu #(.N(N), .INVERT(1'b0)) u_dut (
        .ctl_i(ctl), .a_i(a), .b_i(b), .anc_i(anc),
        .ctl_o(ctl_f), .a_o(a_f), .r_o(r_f), .anc_o(anc_f)
    );

    rev_alu #(.N(N), .INVERT(1'b1)) u_inv (
        .ctl_i(ctl_f), .a_i(a_f), .b_i(r_f), .anc_i(anc_f),
        .ctl_o(ctl_r), .a_o(a_r), .r_o(b_r), .anc_o(anc_r)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s ctl=%b a=%0h b=%0h anc=%0b actual=%0h expected=%0h",
                     req, ctl, a, b, anc, act, exp);
        end
    endtask

    // reference: 1 = value defined by the gate-group rule
    function automatic bit modelled(input logic [4:0] c);
        return !(c[1] && !c[2]);
    endfunction

    function automatic logic [N-1:0] model(input logic [4:0] c, input logic [N-1:0] av,
                                           input logic [N-1:0] bv, input logic an);
        logic [N-1:0] bb;
        logic [N-1:0] s;
        bb = c[4] ? ~bv : bv;
        if (c[2] && c[1]) s = bb + av + N'(c[3] ^ an);
        else if (c[2])    s = bb ^ av;
        else              s = bb;
        return c[0] ? ~s : s;
    endfunction

    function automatic string tag(input logic [4:0] c, input logic an);
        if (an && c != 5'b00100 && c != 5'b00000) return "R8";
        case (c)
            5'b00110: return "R1";
            5'b10111: return "R2";
            5'b11110: return "R3";
            5'b00100: return "R4";
            5'b00000: return "R5";
            default:  return "R6";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [(1<<N)-1:0] seen;
        ctl = '0; a = '0; b = '0; anc = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset/idle state: all-zero inputs give all-zero outputs (R5)
        chk(r_f == '0 && a_f == '0 && anc_f == 1'b0 && ctl_f == '0, "R5",
            int'(r_f), 0);

        for (int c = 0; c < 32; c++) begin
            for (int av = 0; av < (1 << N); av++) begin
                for (int an = 0; an < 2; an++) begin
                    seen = '0;
                    for (int bv = 0; bv < (1 << N); bv++) begin
                        @(posedge clk);
                        ctl = 5'(c); a = N'(av); b = N'(bv); anc = an[0];
                        @(negedge clk);
                        chk(ctl_f == ctl && a_f == a, "R7", int'({ctl_f, a_f}),
                            int'({ctl, a}));
                        chk(anc_f == anc, "R8", int'(anc_f), int'(anc));
                        chk(a_r == a && b_r == b && anc_r == anc && ctl_r == ctl, "R10",
                            int'({anc_r, a_r, b_r}), int'({anc, a, b}));
                        if (modelled(ctl))
                            chk(r_f == model(ctl, a, b, anc), tag(ctl, anc),
                                int'(r_f), int'(model(ctl, a, b, anc)));
                        seen[r_f] = 1'b1;
                    end
                    // R9: all 2^N results distinct
                    chk(&seen, "R9", int'(seen), (1 << (1 << N)) - 1);
                end
            end
        end

        // boundary: wraparound corners for the named operations
        @(posedge clk); ctl = 5'b00110; a = '1; b = 4'd1; anc = 1'b0;
        @(negedge clk); chk(r_f == 4'd0, "R1", int'(r_f), 0);
        @(posedge clk); ctl = 5'b10111; a = 4'd1; b = 4'd0;
        @(negedge clk); chk(r_f == 4'hF, "R2", int'(r_f), 15);
        @(posedge clk); ctl = 5'b11110; a = 4'd0; b = 4'd1;
        @(negedge clk); chk(r_f == 4'hF, "R3", int'(r_f), 15);
        @(posedge clk); ctl = 5'b00110; a = 4'd7; b = 4'd8; anc = 1'b1;
        @(negedge clk); chk(r_f == 4'd0 && anc_f, "R8", int'(r_f), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule